// File: doc/BRIEF.md
# I2C Read-Only Slave with Host-Paced Clock Stretching

This block is an I2C slave that serves reads addressed to a configurable 7-bit address. A fast system clock samples the bus lines through synchronisers. The block drives SCL and SDA only through active-high pull-low enables, which an open-drain pad stage turns into bus levels. It decodes Start and Stop and collects the address byte. When the address matches and the direction bit asks for a read, the block acknowledges. It then keeps SCL low until the local host has supplied the next byte.

The host has a small interface. It writes the byte to send, which also loads the internal shift register. It then raises a separate release strobe that lets the clock go. After each byte the block raises a sticky interrupt flag and a one-cycle pulse. A receiver acknowledge makes the slave stretch the clock again for the next byte. A receiver NACK ends the transfer, clears the status and sends the block back to waiting for a Start.

Top module: `i2cTxSlave`

## Requirements
- R1: When the byte after a Start has its upper seven bits equal to `devAddr` and its bit 0 (direction) equal to 1, `readDir` goes to 1 and `hostBuf` holds that whole byte. While SCL is being held low, `readDir` is 1.
- R2: On a matching read address the slave pulls SDA low during the ninth clock. A different address, or bit 0 equal to 0, gets no acknowledge. In that case both lines stay released and the interrupt flag stays clear until the next Start.
- R3: After the ninth clock of the acknowledged address, and after every byte the master acknowledges, SCL is held low. It is freed only by a `clkRelease` pulse that arrives once `bufFull` is already 1. A release with no prior write, or in the same cycle as the write, has no effect.
- R4: A host write is accepted only while the clock is held. It loads `hostBuf` and the transmit shift register and sets `bufFull`. Writes at any other time leave `hostBuf` and `bufFull` unchanged.
- R5: Data bits go out MSB first. The SDA drive changes only while SCL is low, except when a Start or Stop releases it.
- R6: `irqFlag` is set on the falling edge of the ninth clock of every byte and stays set until `irqClr`. On a conflict, setting wins. `irqPulse` is high for exactly one cycle per byte.
- R7: `bufFull` returns to 0 once the eighth data bit has been shifted out.
- R8: A low SDA at the ninth rising edge of a data byte (ACK) makes the slave hold SCL low again for the next byte.
- R9: A high SDA at that edge (NACK) clears `readDir` and `bufFull`, releases both lines and returns the slave to waiting for a Start.
- R10: A Stop or Start seen in the middle of a transfer aborts to idle. It releases both lines and clears `readDir` and `bufFull`, and a following Start with a matching read address is served again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| devAddr | input | 7 | Slave address to respond to |
| sclIn | input | 1 | Sampled SCL bus level |
| sdaIn | input | 1 | Sampled SDA bus level |
| sclDrvLow | output | 1 | 1 pulls SCL low (stretching) |
| sdaDrvLow | output | 1 | 1 pulls SDA low |
| hostWrEn | input | 1 | Host write strobe for the transmit byte |
| hostWrData | input | 8 | Byte to transmit |
| clkRelease | input | 1 | Host strobe that frees a held SCL |
| irqClr | input | 1 | Clears the interrupt flag |
| hostBuf | output | 8 | Host-visible buffer (received address or byte to send) |
| readDir | output | 1 | Read direction recorded for the current transfer |
| bufFull | output | 1 | Transmit byte loaded and not yet fully shifted |
| irqFlag | output | 1 | Sticky per-byte interrupt flag |
| irqPulse | output | 1 | One-cycle pulse per completed byte |

## Verification
The host write and the clock-release strobe can land in the same system cycle. In that cycle the release must be judged against the buffer state from before the write. The bench raises `hostWrEn` and `clkRelease` on one edge while the clock is held. It then checks that SCL is still low while `bufFull` and `hostBuf` already show the new byte. It also checks that a later lone release then frees the clock and the byte comes out intact.

// File: rtl/i2cTxPkg.sv
package i2cTxPkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(DATA_W);

  typedef enum logic [3:0] {
    S_IDLE,   // waiting for Start
    S_ADDR,   // collecting address bits
    S_ADEC,   // eighth address bit in, decide on next fall
    S_AACK,   // driving address acknowledge
    S_SKIP,   // not addressed, ignore until Start
    S_HOLD,   // SCL stretched, waiting for host
    S_SETUP,  // first data bit on SDA, SCL still held
    S_TX,     // shifting data out
    S_MACK,   // waiting for master acknowledge rise
    S_AEND,   // ack seen, wait ninth fall
    S_NEND    // nack seen, wait ninth fall
  } txStateT;

  typedef struct packed {
    logic hostWrOk;
    logic shiftIn;
    logic capAddr;
    logic drvAck;
    logic drvBit;
    logic txNext;
    logic sdaRel;
    logic irqSet;
    logic clrFull;
    logic clrStatus;
  } dpCtlT;

endpackage

// File: rtl/i2cTxData.sv
module i2cTxData
  import i2cTxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtlT             ctl,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              irqClr,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaS,
  output logic              addrHit,
  output logic              sdaLow,
  output logic [DATA_W-1:0] hostBuf,
  output logic              readDir,
  output logic              bufFull,
  output logic              irqFlag,
  output logic              irqPulse
);

  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic                   sclS, sclPrev, sdaPrev;
  logic [DATA_W-1:0]      rxShift, txShift;
  logic                   wrTake, abortEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
      sclPrev  <= sclS;
      sdaPrev  <= sdaS;
    end
  end

  assign sclS     = sclChain[SYNC_STAGES-1];
  assign sdaS     = sdaChain[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign abortEv  = startDet | stopDet;
  assign addrHit  = (rxShift[DATA_W-1:1] == devAddr) & rxShift[0];
  assign wrTake   = hostWrEn & ctl.hostWrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      hostBuf <= '0;
    end else begin
      if (ctl.shiftIn) rxShift <= {rxShift[DATA_W-2:0], sdaS};
      if (wrTake) txShift <= hostWrData;
      else if (ctl.txNext) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (ctl.capAddr) hostBuf <= rxShift;
      else if (wrTake) hostBuf <= hostWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaLow <= 1'b0;
    else if (ctl.sdaRel) sdaLow <= 1'b0;
    else if (ctl.drvAck) sdaLow <= 1'b1;
    else if (ctl.drvBit) sdaLow <= ~txShift[DATA_W-1];
    else if (ctl.txNext) sdaLow <= ~txShift[DATA_W-2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readDir  <= 1'b0;
      bufFull  <= 1'b0;
      irqFlag  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      if (ctl.clrStatus) readDir <= 1'b0;
      else if (ctl.capAddr) readDir <= 1'b1;
      if (ctl.clrStatus || ctl.clrFull) bufFull <= 1'b0;
      else if (wrTake) bufFull <= 1'b1;
      if (ctl.irqSet) irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;
      irqPulse <= ctl.irqSet;
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLow != $past(sdaLow)) |-> (!$past(sclS) || $past(abortEv))); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag); // R6
  AST_IRQ_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R6
  AST_FULL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> $past(hostWrEn)); // R4

endmodule

// File: rtl/i2cTxCtrl.sv
module i2cTxCtrl
  import i2cTxPkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  sclRise,
  input  logic  sclFall,
  input  logic  startDet,
  input  logic  stopDet,
  input  logic  sdaS,
  input  logic  addrHit,
  input  logic  bufFull,
  input  logic  clkRelease,
  output dpCtlT ctl,
  output logic  sclHold
);

  txStateT          st, stNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNxt;
      cnt <= cntNxt;
    end
  end

  always_comb begin
    stNxt  = st;
    cntNxt = cnt;
    ctl    = '0;
    ctl.hostWrOk = (st == S_HOLD);
    if (stopDet) begin
      stNxt         = S_IDLE;
      ctl.sdaRel    = 1'b1;
      ctl.clrStatus = 1'b1;
    end else if (startDet) begin
      stNxt         = S_ADDR;
      cntNxt        = '0;
      ctl.sdaRel    = 1'b1;
      ctl.clrStatus = 1'b1;
    end else begin
      unique case (st)
        S_ADDR: if (sclRise) begin
          ctl.shiftIn = 1'b1;
          if (cnt == LAST_BIT) stNxt = S_ADEC;
          else cntNxt = cnt + 1'b1;
        end
        S_ADEC: if (sclFall) begin
          if (addrHit) begin
            ctl.capAddr = 1'b1;
            ctl.drvAck  = 1'b1;
            stNxt       = S_AACK;
          end else begin
            stNxt = S_SKIP;
          end
        end
        S_AACK: if (sclFall) begin
          ctl.sdaRel = 1'b1;
          ctl.irqSet = 1'b1;
          stNxt      = S_HOLD;
        end
        S_HOLD: if (clkRelease && bufFull) begin
          ctl.drvBit = 1'b1;
          cntNxt     = '0;
          stNxt      = S_SETUP;
        end
        S_SETUP: stNxt = S_TX;
        S_TX: if (sclFall) begin
          if (cnt == LAST_BIT) begin
            ctl.sdaRel  = 1'b1;
            ctl.clrFull = 1'b1;
            stNxt       = S_MACK;
          end else begin
            ctl.txNext = 1'b1;
            cntNxt     = cnt + 1'b1;
          end
        end
        S_MACK: if (sclRise) begin
          if (sdaS) begin
            ctl.clrStatus = 1'b1;
            stNxt         = S_NEND;
          end else begin
            stNxt = S_AEND;
          end
        end
        S_AEND: if (sclFall) begin
          ctl.irqSet = 1'b1;
          stNxt      = S_HOLD;
        end
        S_NEND: if (sclFall) begin
          ctl.irqSet = 1'b1;
          stNxt      = S_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign sclHold = (st == S_HOLD) || (st == S_SETUP);

  AST_RELEASE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclHold) |-> bufFull); // R3
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_SKIP) |-> !ctl.irqSet && !ctl.drvAck); // R2

endmodule

// File: rtl/i2cTxSlave.sv
module i2cTxSlave
  import i2cTxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [6:0]  devAddr,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sclDrvLow,
  output logic        sdaDrvLow,
  input  logic        hostWrEn,
  input  logic [7:0]  hostWrData,
  input  logic        clkRelease,
  input  logic        irqClr,
  output logic [7:0]  hostBuf,
  output logic        readDir,
  output logic        bufFull,
  output logic        irqFlag,
  output logic        irqPulse
);

  dpCtlT ctl;
  logic  sclRise, sclFall, startDet, stopDet, sdaS, addrHit;

  i2cTxData #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .devAddr(devAddr), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctl(ctl), .hostWrEn(hostWrEn), .hostWrData(hostWrData), .irqClr(irqClr),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .sdaS(sdaS), .addrHit(addrHit), .sdaLow(sdaDrvLow), .hostBuf(hostBuf),
    .readDir(readDir), .bufFull(bufFull), .irqFlag(irqFlag), .irqPulse(irqPulse)
  );

  i2cTxCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .addrHit(addrHit),
    .bufFull(bufFull), .clkRelease(clkRelease), .ctl(ctl), .sclHold(sclDrvLow)
  );

  AST_HOLD_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    sclDrvLow |-> readDir); // R1

endmodule

// File: tb/test_i2cTxSlave.sv
module test_i2cTxSlave;

  localparam int H = 20;
  localparam int WATCHDOG = 150000;
  localparam int NVEC = 5;
  // {address byte, first data byte, second data byte, expect served}
  localparam logic [24:0] VEC [NVEC] = '{
    {8'hB5, 8'hA5, 8'h3C, 1'b1},
    {8'hB4, 8'h00, 8'h00, 1'b0},
    {8'h37, 8'h00, 8'h00, 1'b0},
    {8'hB5, 8'h00, 8'hFF, 1'b1},
    {8'hB5, 8'h81, 8'h7E, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclMLow = 1'b0, sdaMLow = 1'b0;
  logic       sclLine, sdaLine;
  logic       sclDrvLow, sdaDrvLow;
  logic       hostWrEn = 1'b0, clkRelease = 1'b0, irqClr = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostBuf;
  logic       readDir, bufFull, irqFlag, irqPulse;
  int         checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  assign sclLine = ~(sclMLow | sclDrvLow);
  assign sdaLine = ~(sdaMLow | sdaDrvLow);

  i2cTxSlave i_i2cTxSlave (
    .clk(clk), .rstN(rstN), .devAddr(7'h5A), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .clkRelease(clkRelease), .irqClr(irqClr),
    .hostBuf(hostBuf), .readDir(readDir), .bufFull(bufFull),
    .irqFlag(irqFlag), .irqPulse(irqPulse)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitSclHigh();
    while (!sclLine) @(negedge clk);
  endtask

  task automatic mStart();
    sdaMLow = 1'b1; wt(H);
    sclMLow = 1'b1; wt(H/2);
  endtask

  task automatic mStop();
    sdaMLow = 1'b1; wt(H/2);
    sclMLow = 1'b0; waitSclHigh(); wt(H);
    sdaMLow = 1'b0; wt(H);
  endtask

  task automatic mBitW(input logic b);
    sdaMLow = ~b; wt(H);
    sclMLow = 1'b0; waitSclHigh(); wt(H);
    sclMLow = 1'b1; wt(H/2);
  endtask

  task automatic mBitR(output logic b);
    sdaMLow = 1'b0; wt(H);
    sclMLow = 1'b0; waitSclHigh(); wt(H/2);
    b = sdaLine; wt(H/2);
    sclMLow = 1'b1; wt(H/2);
  endtask

  task automatic mByteW(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) mBitW(d[i]);
  endtask

  task automatic mByteR(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      mBitR(b);
      d[i] = b;
    end
  endtask

  task automatic hWrite(input logic [7:0] d);
    @(negedge clk); hostWrEn = 1'b1; hostWrData = d;
    @(negedge clk); hostWrEn = 1'b0;
  endtask

  task automatic hRelease();
    @(negedge clk); clkRelease = 1'b1;
    @(negedge clk); clkRelease = 1'b0;
  endtask

  task automatic hClrIrq();
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
  endtask

  initial begin
    logic       a;
    logic [7:0] r;
    wt(5);
    rstN = 1'b1;
    wt(5);
    // reset state
    chk("R9 reset sclDrvLow", sclDrvLow, 0);
    chk("R9 reset sdaDrvLow", sdaDrvLow, 0);
    chk("R6 reset irqFlag", irqFlag, 0);
    chk("R4 reset bufFull", bufFull, 0);
    chk("R1 reset readDir", readDir, 0);
    // write while idle is ignored
    hWrite(8'h99);
    chk("R4 idle write hostBuf", hostBuf, 8'h00);
    chk("R4 idle write bufFull", bufFull, 0);

    for (int e = 0; e < NVEC; e++) begin
      mStart();
      mByteW(VEC[e][24:17]);
      mBitR(a);
      if (VEC[e][0]) begin
        chk("R2 address ack", a, 0);
        chk("R1 readDir", readDir, 1);
        chk("R1 hostBuf holds address", hostBuf, VEC[e][24:17]);
        chk("R6 irq after address", irqFlag, 1);
        hClrIrq();
        chk("R6 irq cleared", irqFlag, 0);
        sclMLow = 1'b0; wt(40);
        chk("R3 held after address", sclLine, 0);
        hRelease(); wt(10);
        chk("R3 release without write ignored", sclLine, 0);
        @(negedge clk); hostWrEn = 1'b1; hostWrData = VEC[e][16:9]; clkRelease = 1'b1;
        @(negedge clk); hostWrEn = 1'b0; clkRelease = 1'b0;
        wt(10);
        chk("R3 release with same-cycle write ignored", sclLine, 0);
        chk("R4 bufFull after write", bufFull, 1);
        chk("R4 hostBuf after write", hostBuf, VEC[e][16:9]);
        hRelease();
        mByteR(r);
        chk("R5 first byte", r, VEC[e][16:9]);
        chk("R7 bufFull after eight bits", bufFull, 0);
        mBitW(1'b0);
        chk("R6 irq after data byte", irqFlag, 1);
        hClrIrq();
        sclMLow = 1'b0; wt(40);
        chk("R8 held after master ack", sclLine, 0);
        hWrite(VEC[e][8:1]);
        hRelease();
        mByteR(r);
        chk("R5 second byte", r, VEC[e][8:1]);
        mBitW(1'b1);
        wt(5);
        chk("R9 readDir after nack", readDir, 0);
        chk("R9 bufFull after nack", bufFull, 0);
        chk("R9 scl released after nack", sclDrvLow, 0);
        chk("R9 sda released after nack", sdaDrvLow, 0);
        chk("R6 irq after last byte", irqFlag, 1);
        hClrIrq();
        mStop();
      end else begin
        chk("R2 no ack", a, 1);
        mByteW(8'h00);
        chk("R2 sda released while skipped", sdaDrvLow, 0);
        chk("R2 scl released while skipped", sclDrvLow, 0);
        chk("R2 irq quiet while skipped", irqFlag, 0);
        mBitR(a);
        chk("R2 no ack on later byte", a, 1);
        mStop();
      end
    end

    // Stop in the middle of a data byte
    mStart();
    mByteW(8'hB5);
    mBitR(a);
    chk("R10 ack before abort", a, 0);
    hClrIrq();
    sclMLow = 1'b0;
    hWrite(8'hFF);
    hRelease();
    for (int i = 0; i < 3; i++) mBitR(a);
    sdaMLow = 1'b1; wt(H);
    sclMLow = 1'b0; waitSclHigh(); wt(H);
    sdaMLow = 1'b0; wt(10);
    chk("R10 sda released by stop", sdaDrvLow, 0);
    chk("R10 scl released by stop", sclDrvLow, 0);
    chk("R10 bufFull cleared by stop", bufFull, 0);
    chk("R10 readDir cleared by stop", readDir, 0);
    mStart();
    mByteW(8'hB5);
    mBitR(a);
    chk("R10 served again after abort", a, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule